// File: doc/BRIEF.md
# Two-Cluster Register-Location Steering Unit

At rename time, this block chooses which of two execution clusters receives each instruction. For every architectural register it keeps a two-bit presence mask. Bit 0 is set when cluster 0 holds a copy of the value, and bit 1 is set when cluster 1 holds one. For each cluster it also keeps a saturating count of the instructions steered there that have not yet completed.

An instruction whose source values all sit in one cluster goes to that cluster, so dependence chains stay local. When the sources are split between the clusters, the outcome depends on the policy input. The policy can pick a pseudo-random cluster or the less-loaded cluster. It can also override locality whenever the load gap exceeds a runtime threshold. A fourth policy ignores register locations and strictly alternates between the clusters.

The decision is combinational in the cycle the instruction is presented. The presence masks, load counters, random source and alternation pointer update at the following clock edge. A copy-needed flag tells the rename stage that at least one source value must be moved across to the chosen cluster.

Top module: `rms_steer_unit`

## Requirements
- R1: After reset, every presence mask is 2'b11, both load counts are 0, the alternation pointer is 0 and the random register holds 16'hACE1.
- R2: Under policies 0, 1 and 2 (in policy 2 only while the load gap is within the threshold), an instruction goes to the single cluster whose mask bit is set for every valid source, and copy_o is then 0.
- R3: Under policy 0 (random), sources with no common cluster are sent to cluster = bit 0 of the random register. That register shifts left by one on every valid instruction, under every policy, and takes in bit15^bit13^bit12^bit10 as its new bit 0.
- R4: Under policy 1 (least-loaded), sources with no common cluster are sent to the cluster with the smaller load count. A tie goes to cluster 0.
- R5: Under policy 2 (threshold), if the absolute difference of the two load counts is greater than thresh_i, the instruction goes to the less-loaded cluster whatever its sources. Otherwise the policy 1 rule applies.
- R6: Under policy 3 (alternate), cluster_o equals the alternation pointer. The pointer toggles on every valid instruction under every policy.
- R7: Under policies 0 to 2, an instruction with no valid source, or whose sources are all held by both clusters, goes to the less-loaded cluster. A tie goes to cluster 0.
- R8: copy_o is 1 exactly when valid_i is high and some valid source's mask lacks the bit of the chosen cluster.
- R9: On a steered instruction, each valid source gains the chosen cluster's bit. A valid destination's mask then becomes only the chosen cluster's bit, and this write wins when the destination equals a source.
- R10: A cluster's 6-bit load count rises by one when an instruction is steered to it and falls by one on its done_i bit. If both happen in the same cycle, the count is unchanged. The count saturates at 63 and at 0.
- R11: While valid_i is low, copy_o is 0, and no mask, random register or pointer changes. Load counts change only through done_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| mode_i | input | 2 | Policy: 0 random, 1 least-loaded, 2 threshold, 3 alternate |
| thresh_i | input | 6 | Load-gap threshold used by policy 2 |
| src0_vld_i | input | 1 | First source register is used |
| src0_i | input | 5 | First source register number |
| src1_vld_i | input | 1 | Second source register is used |
| src1_i | input | 5 | Second source register number |
| dst_vld_i | input | 1 | Destination register is written |
| dst_i | input | 5 | Destination register number |
| done_i | input | 2 | Per-cluster completion pulses, bit n for cluster n |
| cluster_o | output | 1 | Chosen cluster |
| copy_o | output | 1 | At least one source must be copied to the chosen cluster |

## Verification
A corrupted presence mask does not show at the ports until an instruction reads that register. It then appears in the same cycle as a wrong cluster_o or a wrong copy_o. Load-count errors stay hidden while the loads are balanced. They surface only when a split-source, source-less or threshold decision compares the two counts, so the saturation tests drive one count far from the other and then steer a source-less instruction. A random register that stepped wrongly shows on the next split-source instruction under policy 0. A wrong alternation pointer shows on the very next instruction under policy 3.

// File: rtl/rms_steer_pkg.sv
`timescale 1ns/1ps
package rms_steer_pkg;
    localparam int NUM_CL = 2;

    typedef enum logic [1:0] {
        POL_RANDOM    = 2'd0,
        POL_LEASTLOAD = 2'd1,
        POL_THRESH    = 2'd2,
        POL_ALTERNATE = 2'd3
    } steer_pol_e;

    typedef logic [NUM_CL-1:0] cl_mask_t;

    typedef struct packed {
        logic alt;
    } top_state_t;
endpackage

// File: rtl/rms_lfsr.sv
`timescale 1ns/1ps
module rms_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] SEED  = 16'hACE1,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic rnd_o
);
    logic [WIDTH-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (adv_i) lfsr_d = {lfsr_q[WIDTH-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q[0];
endmodule

// File: rtl/rms_load_ctr.sv
`timescale 1ns/1ps
module rms_load_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (dec_i && !inc_i && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rms_presence_tbl.sv
`timescale 1ns/1ps
module rms_presence_tbl
    import rms_steer_pkg::*;
#(
    parameter int NUM_AREG = 32,
    localparam int AREG_W  = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREG_W-1:0] ra0_i,
    input  logic [AREG_W-1:0] ra1_i,
    output cl_mask_t          rm0_o,
    output cl_mask_t          rm1_o,
    input  logic              upd_i,
    input  logic              cl_i,
    input  logic              sv0_i,
    input  logic              sv1_i,
    input  logic              dv_i,
    input  logic [AREG_W-1:0] da_i
);
    cl_mask_t tbl_d [NUM_AREG];
    cl_mask_t tbl_q [NUM_AREG];
    cl_mask_t own_mask;

    assign own_mask = cl_mask_t'(1) << cl_i;

    always_comb begin
        tbl_d = tbl_q;
        if (upd_i) begin
            if (sv0_i) tbl_d[ra0_i] = tbl_q[ra0_i] | own_mask;
            if (sv1_i) tbl_d[ra1_i] = tbl_d[ra1_i] | own_mask;
            if (dv_i)  tbl_d[da_i]  = own_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '{default: '1};
        else        tbl_q <= tbl_d;
    end

    assign rm0_o = tbl_q[ra0_i];
    assign rm1_o = tbl_q[ra1_i];
endmodule

// File: rtl/rms_steer_unit.sv
`timescale 1ns/1ps
module rms_steer_unit
    import rms_steer_pkg::*;
#(
    parameter int NUM_AREG = 32,
    parameter int LOAD_W   = 6,
    parameter int LFSR_W   = 16,
    localparam int AREG_W  = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        mode_i,
    input  logic [LOAD_W-1:0] thresh_i,
    input  logic              src0_vld_i,
    input  logic [AREG_W-1:0] src0_i,
    input  logic              src1_vld_i,
    input  logic [AREG_W-1:0] src1_i,
    input  logic              dst_vld_i,
    input  logic [AREG_W-1:0] dst_i,
    input  logic [1:0]        done_i,
    output logic              cluster_o,
    output logic              copy_o
);
    top_state_t        st_d, st_q;
    steer_pol_e        pol;
    cl_mask_t          mask0_w, mask1_w;
    logic [LOAD_W-1:0] load_w [NUM_CL];
    logic [LOAD_W-1:0] gap;
    logic              rnd_w, pick, less, hold0, hold1, big_gap;

    assign pol = steer_pol_e'(mode_i);

    rms_presence_tbl #(.NUM_AREG(NUM_AREG)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .ra0_i(src0_i), .ra1_i(src1_i), .rm0_o(mask0_w), .rm1_o(mask1_w),
        .upd_i(valid_i), .cl_i(pick), .sv0_i(src0_vld_i), .sv1_i(src1_vld_i),
        .dv_i(dst_vld_i), .da_i(dst_i)
    );

    rms_lfsr #(.WIDTH(LFSR_W)) u_rnd (
        .clk(clk), .rst_n(rst_n), .adv_i(valid_i), .rnd_o(rnd_w)
    );

    for (genvar g = 0; g < NUM_CL; g++) begin : g_load
        rms_load_ctr #(.CNT_W(LOAD_W)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .inc_i(valid_i && (pick == 1'(g))),
            .dec_i(done_i[g]),
            .cnt_o(load_w[g])
        );
    end

    always_comb begin
        st_d  = st_q;
        hold0 = (!src0_vld_i || mask0_w[0]) && (!src1_vld_i || mask1_w[0]);
        hold1 = (!src0_vld_i || mask0_w[1]) && (!src1_vld_i || mask1_w[1]);
        less  = (load_w[1] < load_w[0]);
        gap   = (load_w[0] > load_w[1]) ? (load_w[0] - load_w[1])
                                        : (load_w[1] - load_w[0]);
        big_gap = (gap > thresh_i);

        if (pol == POL_ALTERNATE)               pick = st_q.alt;
        else if (pol == POL_THRESH && big_gap)  pick = less;
        else if (hold0 && hold1)                pick = less;
        else if (hold0)                         pick = 1'b0;
        else if (hold1)                         pick = 1'b1;
        else if (pol == POL_RANDOM)             pick = rnd_w;
        else                                    pick = less;

        copy_o = valid_i && ((src0_vld_i && !mask0_w[pick]) ||
                             (src1_vld_i && !mask1_w[pick]));
        if (valid_i) st_d.alt = ~st_q.alt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cluster_o = pick;
endmodule

// File: rtl/rms_steer_chk.sv
`timescale 1ns/1ps
module rms_steer_chk #(
    parameter int LOAD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic [1:0]        mode,
    input logic [LOAD_W-1:0] thresh,
    input logic              s0v,
    input logic              s1v,
    input logic [1:0]        m0,
    input logic [LOAD_W-1:0] load0,
    input logic [LOAD_W-1:0] load1,
    input logic              cluster,
    input logic              copy
);
    // R6: back-to-back alternate-policy instructions land in different clusters
    a_r6_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 2'd3 && $past(valid && mode == 2'd3))
        |-> (cluster != $past(cluster)));

    // R2: a single source held in one cluster only keeps the instruction local
    a_r2_local_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode <= 2'd1 && s0v && !s1v && $countones(m0) == 1)
        |-> (cluster == m0[1] && !copy));

    // R8: no sources means nothing to copy
    a_r8_no_src_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !s0v && !s1v) |-> !copy);

    // R5: a load gap beyond the threshold forces the lighter cluster
    a_r5_heavy0_avoided: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 2'd2 &&
         ({1'b0, load0} > {1'b0, load1} + {1'b0, thresh})) |-> (cluster == 1'b1));
    a_r5_heavy1_avoided: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == 2'd2 &&
         ({1'b0, load1} > {1'b0, load0} + {1'b0, thresh})) |-> (cluster == 1'b0));

    // R10: a load count moves by at most one per cycle
    a_r10_load0_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ({1'b0, load0} == {1'b0, $past(load0)} ||
                  {1'b0, load0} == {1'b0, $past(load0)} + 7'd1 ||
                  {1'b0, load0} + 7'd1 == {1'b0, $past(load0)}));

    // R11: an idle cycle never asks for a copy
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !copy);
endmodule

bind rms_steer_unit rms_steer_chk #(.LOAD_W(LOAD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid_i), .mode(mode_i), .thresh(thresh_i),
    .s0v(src0_vld_i), .s1v(src1_vld_i), .m0(mask0_w),
    .load0(load_w[0]), .load1(load_w[1]), .cluster(cluster_o), .copy(copy_o)
);

// File: tb/rms_steer_unit_test.sv
`timescale 1ns/1ps
module rms_steer_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid_i, src0_vld_i, src1_vld_i, dst_vld_i;
    logic [1:0] mode_i, done_i;
    logic [5:0] thresh_i;
    logic [4:0] src0_i, src1_i, dst_i;
    logic       cluster_o, copy_o;

    always #2 clk = ~clk;

    rms_steer_unit uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .thresh_i(thresh_i), .src0_vld_i(src0_vld_i), .src0_i(src0_i),
        .src1_vld_i(src1_vld_i), .src1_i(src1_i), .dst_vld_i(dst_vld_i),
        .dst_i(dst_i), .done_i(done_i), .cluster_o(cluster_o), .copy_o(copy_o)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    logic [1:0] mm [32];
    int         ld [2];
    logic [15:0] lf;
    logic       alt;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_loads(bit inc_v, int c, logic [1:0] dn);
        for (int k = 0; k < 2; k++) begin
            bit up = inc_v && (c == k);
            if (up && !dn[k])      ld[k] = (ld[k] < 63) ? ld[k] + 1 : 63;
            else if (dn[k] && !up) ld[k] = (ld[k] > 0) ? ld[k] - 1 : 0;
        end
    endtask

    task automatic release_inputs();
        @(posedge clk);
        #1;
        valid_i = 1'b0;
        done_i  = 2'b00;
    endtask

    task automatic step(string req, int md, int thr, bit s0v, int s0,
                        bit s1v, int s1, bit dv, int d, logic [1:0] dn);
        int pick, less, diff;
        bit h0, h1, cp;
        @(negedge clk);
        valid_i = 1'b1; mode_i = 2'(md); thresh_i = 6'(thr);
        src0_vld_i = s0v; src0_i = 5'(s0); src1_vld_i = s1v; src1_i = 5'(s1);
        dst_vld_i = dv; dst_i = 5'(d); done_i = dn;
        h0 = (!s0v || mm[s0][0]) && (!s1v || mm[s1][0]);
        h1 = (!s0v || mm[s0][1]) && (!s1v || mm[s1][1]);
        less = (ld[1] < ld[0]) ? 1 : 0;
        diff = (ld[0] > ld[1]) ? ld[0] - ld[1] : ld[1] - ld[0];
        if (md == 3)                  pick = int'(alt);
        else if (md == 2 && diff > thr) pick = less;
        else if (h0 && h1)            pick = less;
        else if (h0)                  pick = 0;
        else if (h1)                  pick = 1;
        else if (md == 0)             pick = int'(lf[0]);
        else                          pick = less;
        cp = (s0v && !mm[s0][pick]) || (s1v && !mm[s1][pick]);
        #1;
        chk(req, "cluster", int'(cluster_o), pick);
        chk(req, "copy", int'(copy_o), int'(cp));
        if (s0v) mm[s0][pick] = 1'b1;
        if (s1v) mm[s1][pick] = 1'b1;
        if (dv)  mm[d] = (pick == 1) ? 2'b10 : 2'b01;
        model_loads(1'b1, pick, dn);
        lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        alt = ~alt;
        release_inputs();
    endtask

    task automatic idle(logic [1:0] dn);
        @(negedge clk);
        valid_i = 1'b0; mode_i = 2'd0; src0_vld_i = 1'b1; src0_i = 5'd7;
        src1_vld_i = 1'b1; src1_i = 5'd9; dst_vld_i = 1'b1; dst_i = 5'd7;
        done_i = dn;
        #1;
        chk("R11", "idle copy", int'(copy_o), 0);
        model_loads(1'b0, 0, dn);
        release_inputs();
    endtask

    task automatic drain();
        for (int i = 0; i < 64; i++) idle(2'b11);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; valid_i = 1'b0; done_i = 2'b00; mode_i = 2'd0;
        thresh_i = '0; src0_vld_i = 0; src1_vld_i = 0; dst_vld_i = 0;
        src0_i = '0; src1_i = '0; dst_i = '0;
        for (int i = 0; i < 32; i++) mm[i] = 2'b11;
        ld[0] = 0; ld[1] = 0; lf = 16'hACE1; alt = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: the first source-less instruction sees equal loads and goes to cluster 0
        step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
        step("R7", 1, 0, 1, 3, 1, 4, 0, 0, 2'b00);
        step("R1", 3, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    endtask

    task automatic t_locality();
        step("R6", 3, 0, 0, 0, 0, 0, 1, 3, 2'b00);
        step("R6", 3, 0, 0, 0, 0, 0, 1, 4, 2'b00);
        step("R6", 3, 0, 1, 3, 1, 4, 1, 5, 2'b00);
        step("R2", 1, 0, 1, 3, 0, 0, 1, 6, 2'b00);
        step("R2", 0, 0, 1, 4, 0, 0, 1, 8, 2'b00);
        step("R4", 1, 0, 1, 6, 1, 8, 1, 9, 2'b00);
        step("R9", 1, 0, 1, 6, 1, 8, 0, 0, 2'b00);
        step("R8", 1, 0, 1, 9, 1, 9, 1, 9, 2'b00);
    endtask

    task automatic t_random();
        for (int i = 0; i < 12; i++) begin
            step("R6", 3, 0, 0, 0, 0, 0, 1, 10, 2'b00);
            step("R6", 3, 0, 0, 0, 0, 0, 1, 11, 2'b00);
            step("R3", 0, 0, 1, 10, 1, 11, 1, 12, 2'b00);
            step("R3", (i % 2 == 0) ? 1 : 2, 63, 0, 0, 0, 0, 0, 0, 2'b00);
        end
    endtask

    task automatic t_advanced();
        drain();
        step("R7", 1, 0, 0, 0, 0, 0, 1, 20, 2'b00);
        step("R7", 1, 0, 0, 0, 0, 0, 1, 23, 2'b00);
        for (int i = 0; i < 10; i++) step("R2", 1, 0, 1, 20, 0, 0, 1, 20, 2'b00);
        step("R5", 2, 40, 1, 20, 0, 0, 1, 24, 2'b00);
        step("R5", 2, 3, 1, 20, 0, 0, 1, 21, 2'b00);
        step("R5", 2, 3, 1, 20, 1, 23, 1, 22, 2'b00);
        step("R5", 2, 63, 1, 21, 1, 24, 1, 25, 2'b00);
    endtask

    task automatic t_saturate();
        drain();
        step("R10", 1, 0, 0, 0, 0, 0, 1, 1, 2'b00);
        for (int i = 0; i < 70; i++) step("R10", 1, 0, 1, 1, 0, 0, 1, 1, 2'b00);
        step("R10", 1, 0, 0, 0, 0, 0, 1, 2, 2'b00);
        for (int i = 0; i < 10; i++) step("R10", 1, 0, 1, 2, 0, 0, 1, 2, 2'b00);
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
        for (int i = 0; i < 20; i++) idle(2'b10);
        step("R10", 1, 0, 1, 2, 0, 0, 0, 0, 2'b10);
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 2'b01);
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 2'b00);
    endtask

    task automatic t_idle();
        step("R11", 3, 0, 0, 0, 0, 0, 1, 14, 2'b00);
        for (int i = 0; i < 5; i++) idle(2'b00);
        step("R11", 3, 0, 1, 14, 0, 0, 0, 0, 2'b00);
        step("R11", 0, 0, 1, 14, 1, 7, 1, 15, 2'b00);
        step("R9", 3, 0, 1, 15, 0, 0, 1, 15, 2'b00);
        step("R9", 1, 0, 1, 15, 0, 0, 0, 0, 2'b00);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_locality();
        t_random();
        t_advanced();
        t_saturate();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule